// File: doc/BRIEF.md
# Prescaled Match Timer with PWM Outputs

A 16-bit up-counter driven through a prescaler. Four compare registers watch the count. Each compare can do up to three things when it hits: raise an interrupt flag, return the count to zero, or halt the counter. Three of the compares also drive output pins. Each pin runs in one of two modes. In pulse-width mode the pin goes high when its compare hits and goes low when the count is wrapped to zero. In event mode the pin is set, cleared or toggled by a per-channel action code.

Software programs the block through a flat map of word registers. Writes take effect at the next clock edge, and reads return data in the same cycle. A typical setup points compare 3 at the period value with its wrap action, points compares 0 to 2 at the duty thresholds, selects pulse-width mode for the pins, and sets the run bit.

Top module: `tmr_pwm16`

## Requirements
- R1: Bit 0 of the control word at byte address 0x00 is the run bit. While it is 0 and no bus write targets a counter, the prescale counter (0x08) and the main count (0x0C) keep their values.
- R2: Bit 1 of the control word is a hold-clear. On every clock edge where it is 1, both counters are forced to zero and all pulse-width pin states go low, whatever else happens. Counting resumes from zero once it is written back to 0.
- R3: While running, the prescale counter steps by one per clock. When it equals the limit at 0x04 it returns to 0, and in that same cycle the count advances. After k running clocks the prescale counter reads k mod (P+1), where P is the limit.
- R4: Compare register n sits at 0x20+4n. Its action bits in the action word at 0x10 are: bit 3n for interrupt, bit 3n+1 for wrap, bit 3n+2 for halt. On an advance cycle where the count equals compare n and the wrap bit is set, the count goes to 0 instead of incrementing. With compare 3 set to C and wrapping, the count after k running clocks is floor(k/(P+1)) mod (C+1).
- R5: On an advance cycle where the count equals a compare whose halt bit is set, the count keeps its value, the prescale counter wraps to 0, and the run bit reads back 0.
- R6: Bit n of the mode word at 0x18 set to 1 puts pin n into pulse-width mode. The pin rises after its compare hits and falls on the edge where a wrap occurs. If both happen on the same edge, the fall wins. In a wrapping setup the pin equals (count > compare n).
- R7: Flag n of the flag word at 0x14 is set when compare n hits with its interrupt bit set. Hits on compares without that bit leave their flag at 0. Writing 1 to a flag bit clears it, and a new hit in the same cycle wins over the clear. The irq output is high while any flag is set.
- R8: With mode bit n at 0, pin n follows bit n of the event word at 0x1C. A bus write there loads the state directly. On a hit of compare n, the 2-bit code at bits 4+2n and 5+2n acts on the state: 0 keeps it, 1 clears it, 2 sets it, 3 toggles it. The current state reads back from bits 2:0.
- R9: After reset, every register reads 0, all pins are low, and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| match_out | output | 3 | Compare-driven output pins |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
The checker watches the cycle-level rules on every clock. It checks that a held clear zeroes the counters, that an idle timer keeps its counters still, that the prescaler wraps at its limit, and that a wrap returns the count to zero. It also checks that a halt drops the run bit, that a wrap pulls every pulse-width pin low, that a compare hit raises its pulse-width pin, and that a new flag raises irq. Some behaviours can only be shown by the bench's scenarios: the exact period and duty arithmetic across a sweep of prescale, period and threshold values; the dwell value at which a halted count stops; the set, clear, toggle and keep sequence of the event pins; and the write-one-to-clear timing of the flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W  = 16;
    localparam int TMR_N_CMP  = 4;
    localparam int TMR_N_OUT  = 3;
    localparam int TMR_DATA_W = 32;
    localparam int TMR_ADDR_W = 6;

    // word index = byte address / 4
    localparam logic [3:0] RI_CTRL  = 4'd0;
    localparam logic [3:0] RI_PSLIM = 4'd1;
    localparam logic [3:0] RI_PSCNT = 4'd2;
    localparam logic [3:0] RI_COUNT = 4'd3;
    localparam logic [3:0] RI_ACT   = 4'd4;
    localparam logic [3:0] RI_FLAG  = 4'd5;
    localparam logic [3:0] RI_MODE  = 4'd6;
    localparam logic [3:0] RI_EXT   = 4'd7;
    localparam logic [3:0] RI_CMP0  = 4'd8;

    localparam int EXT_ACT_LSB = 4;
    localparam int ACT_BITS    = 3;

    typedef enum logic [1:0] {
        EXT_KEEP = 2'd0,
        EXT_LOW  = 2'd1,
        EXT_HIGH = 2'd2,
        EXT_FLIP = 2'd3
    } ext_act_e;

    typedef struct packed {
        logic halt;
        logic wrap;
        logic irq;
    } match_act_t;

    typedef struct packed {
        logic clr;
        logic run;
    } ctrl_t;

    function automatic logic ext_next(input logic cur, input ext_act_e a);
        case (a)
            EXT_LOW:  return 1'b0;
            EXT_HIGH: return 1'b1;
            EXT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         tick
);

    logic at_limit;
    assign at_limit = (cnt == limit);
    assign tick     = run && !clr && !wr_en && at_limit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (run) begin
            cnt <= at_limit ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         tick,
    input  logic         wrap_evt,
    input  logic         halt_evt,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (tick) begin
            if (wrap_evt)
                cnt <= '0;
            else if (!halt_evt)
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_match.sv
module tmr_match import tmr_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 4
) (
    input  logic                         tick,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [N_CMP-1:0][CNT_W-1:0]  cmp,
    input  match_act_t [N_CMP-1:0]       act,
    output logic [N_CMP-1:0]             hit,
    output logic [N_CMP-1:0]             irq_set,
    output logic                         wrap_evt,
    output logic                         halt_evt
);

    logic [N_CMP-1:0] wrap_v;
    logic [N_CMP-1:0] halt_v;

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign hit[g]     = tick && (cnt == cmp[g]);
        assign irq_set[g] = hit[g] && act[g].irq;
        assign wrap_v[g]  = hit[g] && act[g].wrap;
        assign halt_v[g]  = hit[g] && act[g].halt;
    end

    assign wrap_evt = |wrap_v;
    assign halt_evt = |halt_v;

endmodule

// File: rtl/tmr_outputs.sv
module tmr_outputs import tmr_pkg::*; #(
    parameter int N_OUT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_OUT-1:0]       hit,
    input  logic                   pwm_clr,
    input  logic [N_OUT-1:0]       mode,
    input  logic [N_OUT-1:0][1:0]  ext_act,
    input  logic                   ext_wr,
    input  logic [N_OUT-1:0]       ext_wval,
    output logic [N_OUT-1:0]       ext_state,
    output logic [N_OUT-1:0]       pin
);

    logic [N_OUT-1:0] pwm_q;

    for (genvar g = 0; g < N_OUT; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || pwm_clr)
                pwm_q[g] <= 1'b0;
            else if (hit[g])
                pwm_q[g] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst)
                ext_state[g] <= 1'b0;
            else if (ext_wr)
                ext_state[g] <= ext_wval[g];
            else if (hit[g])
                ext_state[g] <= ext_next(ext_state[g], ext_act_e'(ext_act[g]));
        end

        assign pin[g] = mode[g] ? pwm_q[g] : ext_state[g];
    end

endmodule

// File: rtl/tmr_pwm16.sv
module tmr_pwm16 import tmr_pkg::*; #(
    parameter int CNT_W  = TMR_CNT_W,
    parameter int N_CMP  = TMR_N_CMP,
    parameter int N_OUT  = TMR_N_OUT,
    parameter int DATA_W = TMR_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [TMR_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [N_OUT-1:0]      match_out,
    output logic                  irq
);

    localparam int ACT_W = ACT_BITS * N_CMP;
    localparam int EXT_W = 2 * N_OUT;

    logic [3:0] widx;
    assign widx = bus_addr[TMR_ADDR_W-1:2];

    logic wr_ctrl, wr_pslim, wr_pscnt, wr_count, wr_act, wr_flag, wr_mode, wr_ext;
    assign wr_ctrl  = bus_wr && (widx == RI_CTRL);
    assign wr_pslim = bus_wr && (widx == RI_PSLIM);
    assign wr_pscnt = bus_wr && (widx == RI_PSCNT);
    assign wr_count = bus_wr && (widx == RI_COUNT);
    assign wr_act   = bus_wr && (widx == RI_ACT);
    assign wr_flag  = bus_wr && (widx == RI_FLAG);
    assign wr_mode  = bus_wr && (widx == RI_MODE);
    assign wr_ext   = bus_wr && (widx == RI_EXT);

    ctrl_t                        ctrl_q;
    logic                         run_q, clr_q;
    logic [CNT_W-1:0]             ps_lim;
    logic [CNT_W-1:0]             ps_cnt;
    logic [CNT_W-1:0]             tmr_cnt;
    match_act_t [N_CMP-1:0]       act_q;
    logic [N_CMP-1:0]             flags_q;
    logic [N_OUT-1:0]             mode_q;
    logic [N_OUT-1:0][1:0]        ext_act_q;
    logic [N_OUT-1:0]             ext_state;
    logic [N_CMP-1:0][CNT_W-1:0]  cmp_q;

    logic                         tick;
    logic [N_CMP-1:0]             hit;
    logic [N_CMP-1:0]             irq_set;
    logic                         wrap_evt, halt_evt;

    assign run_q = ctrl_q.run;
    assign clr_q = ctrl_q.clr;

    // control word: bus write wins over a halt
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run <= bus_wdata[0];
            ctrl_q.clr <= bus_wdata[1];
        end else if (halt_evt) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_lim    <= '0;
            act_q     <= '0;
            mode_q    <= '0;
            ext_act_q <= '0;
        end else begin
            if (wr_pslim) ps_lim    <= bus_wdata[CNT_W-1:0];
            if (wr_act)   act_q     <= bus_wdata[ACT_W-1:0];
            if (wr_mode)  mode_q    <= bus_wdata[N_OUT-1:0];
            if (wr_ext)   ext_act_q <= bus_wdata[EXT_ACT_LSB +: EXT_W];
        end
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp_reg
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[g] <= '0;
            else if (bus_wr && (widx == RI_CMP0 + 4'(g)))
                cmp_q[g] <= bus_wdata[CNT_W-1:0];
        end
    end

    // flags: a new hit wins over a write-one clear
    logic [N_CMP-1:0] flag_clr;
    assign flag_clr = wr_flag ? bus_wdata[N_CMP-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~flag_clr) | irq_set;
    end

    assign irq = |flags_q;

    tmr_prescaler #(.W(CNT_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .clr    (clr_q),
        .wr_en  (wr_pscnt),
        .wr_val (bus_wdata[CNT_W-1:0]),
        .limit  (ps_lim),
        .cnt    (ps_cnt),
        .tick   (tick)
    );

    tmr_match #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_match (
        .tick     (tick),
        .cnt      (tmr_cnt),
        .cmp      (cmp_q),
        .act      (act_q),
        .hit      (hit),
        .irq_set  (irq_set),
        .wrap_evt (wrap_evt),
        .halt_evt (halt_evt)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_q),
        .wr_en    (wr_count),
        .wr_val   (bus_wdata[CNT_W-1:0]),
        .tick     (tick),
        .wrap_evt (wrap_evt),
        .halt_evt (halt_evt),
        .cnt      (tmr_cnt)
    );

    tmr_outputs #(.N_OUT(N_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit[N_OUT-1:0]),
        .pwm_clr   (wrap_evt || clr_q),
        .mode      (mode_q),
        .ext_act   (ext_act_q),
        .ext_wr    (wr_ext),
        .ext_wval  (bus_wdata[N_OUT-1:0]),
        .ext_state (ext_state),
        .pin       (match_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (widx)
            RI_CTRL:  bus_rdata[1:0] = ctrl_q;
            RI_PSLIM: bus_rdata[CNT_W-1:0] = ps_lim;
            RI_PSCNT: bus_rdata[CNT_W-1:0] = ps_cnt;
            RI_COUNT: bus_rdata[CNT_W-1:0] = tmr_cnt;
            RI_ACT:   bus_rdata[ACT_W-1:0] = act_q;
            RI_FLAG:  bus_rdata[N_CMP-1:0] = flags_q;
            RI_MODE:  bus_rdata[N_OUT-1:0] = mode_q;
            RI_EXT: begin
                bus_rdata[N_OUT-1:0]            = ext_state;
                bus_rdata[EXT_ACT_LSB +: EXT_W] = ext_act_q;
            end
            default: begin
                for (int i = 0; i < N_CMP; i++)
                    if (widx == RI_CMP0 + 4'(i))
                        bus_rdata[CNT_W-1:0] = cmp_q[i];
            end
        endcase
    end

endmodule

// File: rtl/tmr_pwm16_chk.sv
module tmr_pwm16_chk import tmr_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 4,
    parameter int N_OUT = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [TMR_ADDR_W-1:0] bus_addr,
    input logic                  run_q,
    input logic                  clr_q,
    input logic [CNT_W-1:0]      ps_lim,
    input logic [CNT_W-1:0]      ps_cnt,
    input logic [CNT_W-1:0]      tmr_cnt,
    input logic [N_CMP-1:0]      hit,
    input logic [N_CMP-1:0]      irq_set,
    input logic                  wrap_evt,
    input logic                  halt_evt,
    input logic [N_OUT-1:0]      mode_q,
    input logic [N_OUT-1:0]      match_out,
    input logic                  irq
);

    logic [3:0] widx;
    logic ctrl_wr, pscnt_wr, count_wr, mode_wr;
    assign widx     = bus_addr[TMR_ADDR_W-1:2];
    assign ctrl_wr  = bus_wr && (widx == RI_CTRL);
    assign pscnt_wr = bus_wr && (widx == RI_PSCNT);
    assign count_wr = bus_wr && (widx == RI_COUNT);
    assign mode_wr  = bus_wr && (widx == RI_MODE);

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> (tmr_cnt == '0 && ps_cnt == '0));

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !clr_q && !pscnt_wr && !count_wr) |=> ($stable(tmr_cnt) && $stable(ps_cnt)));

    a_r3_prescale_wrap: assert property (@(posedge clk) disable iff (rst)
        (run_q && !clr_q && !pscnt_wr && ps_cnt == ps_lim) |=> (ps_cnt == '0));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !clr_q && !count_wr) |=> (tmr_cnt == '0));

    a_r5_halt_stops: assert property (@(posedge clk) disable iff (rst)
        (halt_evt && !ctrl_wr) |=> !run_q);

    a_r6_wrap_drops_pwm: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !mode_wr) |=> ((match_out & mode_q) == '0));

    for (genvar g = 0; g < N_OUT; g++) begin : g_pwm_chk
        a_r6_hit_raises_pwm: assert property (@(posedge clk) disable iff (rst)
            (hit[g] && !wrap_evt && !clr_q && mode_q[g] && !mode_wr) |=> match_out[g]);
    end

    a_r7_flag_irq: assert property (@(posedge clk) disable iff (rst)
        (|irq_set) |=> irq);

endmodule

bind tmr_pwm16 tmr_pwm16_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .run_q     (run_q),
    .clr_q     (clr_q),
    .ps_lim    (ps_lim),
    .ps_cnt    (ps_cnt),
    .tmr_cnt   (tmr_cnt),
    .hit       (hit),
    .irq_set   (irq_set),
    .wrap_evt  (wrap_evt),
    .halt_evt  (halt_evt),
    .mode_q    (mode_q),
    .match_out (match_out),
    .irq       (irq)
);

// File: tb/tmr_pwm16_tb.sv
module tmr_pwm16_tb;

    localparam logic [5:0] A_CTRL  = 6'h00;
    localparam logic [5:0] A_PSLIM = 6'h04;
    localparam logic [5:0] A_PSCNT = 6'h08;
    localparam logic [5:0] A_COUNT = 6'h0C;
    localparam logic [5:0] A_ACT   = 6'h10;
    localparam logic [5:0] A_FLAG  = 6'h14;
    localparam logic [5:0] A_MODE  = 6'h18;
    localparam logic [5:0] A_EXT   = 6'h1C;
    localparam logic [5:0] A_CMP0  = 6'h20;
    localparam logic [5:0] A_CMP1  = 6'h24;
    localparam logic [5:0] A_CMP2  = 6'h28;
    localparam logic [5:0] A_CMP3  = 6'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  match_out;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    tmr_pwm16 u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .match_out (match_out),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // called at a negedge; one clock edge passes
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t, cv, c0, c1, c2;
        logic [2:0] pexp;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk("R9 pins", {29'd0, match_out}, 32'd0);
        chk("R9 irq", {31'd0, irq}, 32'd0);
        rd(A_CTRL, d);  chk("R9 ctrl", d, 32'd0);
        rd(A_COUNT, d); chk("R9 count", d, 32'd0);
        rd(A_FLAG, d);  chk("R9 flags", d, 32'd0);
        rd(A_EXT, d);   chk("R9 event", d, 32'd0);

        // R3 R4 R6 sweep over prescale, period and thresholds
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 5; c++) begin
                for (int a = 0; a <= c + 1; a++) begin
                    c0 = a;
                    c1 = (a == 0) ? c : a - 1;
                    c2 = c + 1 - a;
                    wr(A_CTRL, 32'd2);
                    wr(A_PSLIM, p);
                    wr(A_CMP0, c0);
                    wr(A_CMP1, c1);
                    wr(A_CMP2, c2);
                    wr(A_CMP3, c);
                    wr(A_ACT, 32'h400);
                    wr(A_MODE, 32'd7);
                    wr(A_CTRL, 32'd1);
                    for (int k = 0; k <= 2 * (c + 1) * (p + 1) + 1; k++) begin
                        t  = k / (p + 1);
                        cv = t % (c + 1);
                        pexp = {cv > c2, cv > c1, cv > c0};
                        rd(A_COUNT, d); chk("R4 count", d, cv);
                        rd(A_PSCNT, d); chk("R3 prescale", d, k % (p + 1));
                        chk("R6 pwm pins", {29'd0, match_out}, {29'd0, pexp});
                        @(negedge clk);
                    end
                end
            end
        end

        // R7 interrupt flags
        wr(A_CTRL, 32'd2);
        wr(A_PSLIM, 32'd0);
        wr(A_CMP0, 32'd2);
        wr(A_CMP1, 32'd2);
        wr(A_CMP3, 32'd5);
        wr(A_ACT, 32'h401);
        wr(A_MODE, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(2);
        rd(A_FLAG, d); chk("R7 flags before hit", d, 32'd0);
        idle(1);
        rd(A_FLAG, d); chk("R7 flag set, others masked", d, 32'd1);
        chk("R7 irq high", {31'd0, irq}, 32'd1);
        wr(A_FLAG, 32'd1);
        rd(A_FLAG, d); chk("R7 flag cleared", d, 32'd0);
        chk("R7 irq low", {31'd0, irq}, 32'd0);
        idle(5);
        rd(A_FLAG, d); chk("R7 flag set again", d, 32'd1);

        // R1 run bit off holds counters
        wr(A_CTRL, 32'd0);
        rd(A_COUNT, d); chk("R1 count at stop", d, 32'd4);
        idle(7);
        rd(A_COUNT, d); chk("R1 count held", d, 32'd4);
        rd(A_PSCNT, d); chk("R1 prescale held", d, 32'd0);
        wr(A_FLAG, 32'hF);

        // R2 hold-clear
        wr(A_CTRL, 32'd3);
        idle(5);
        rd(A_COUNT, d); chk("R2 count zero", d, 32'd0);
        rd(A_PSCNT, d); chk("R2 prescale zero", d, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(3);
        rd(A_COUNT, d); chk("R2 resumes from zero", d, 32'd3);

        // R5 halt on compare 1
        wr(A_CTRL, 32'd2);
        wr(A_PSLIM, 32'd1);
        wr(A_CMP1, 32'd3);
        wr(A_CMP3, 32'd100);
        wr(A_ACT, 32'h020);
        wr(A_CTRL, 32'd1);
        idle(7);
        rd(A_CTRL, d); chk("R5 still running", d, 32'd1);
        idle(5);
        rd(A_COUNT, d); chk("R5 count halted", d, 32'd3);
        rd(A_CTRL, d);  chk("R5 run bit cleared", d, 32'd0);
        rd(A_PSCNT, d); chk("R5 prescale wrapped", d, 32'd0);

        // R8 event-mode pins
        wr(A_CTRL, 32'd2);
        wr(A_PSLIM, 32'd0);
        wr(A_CMP0, 32'd1);
        wr(A_CMP1, 32'd1);
        wr(A_CMP2, 32'd1);
        wr(A_CMP3, 32'd3);
        wr(A_ACT, 32'h400);
        wr(A_MODE, 32'd0);
        wr(A_EXT, 32'h1B4);
        wr(A_CTRL, 32'd1);
        chk("R8 loaded state", {29'd0, match_out}, 32'd4);
        idle(1);
        chk("R8 before hit", {29'd0, match_out}, 32'd4);
        idle(1);
        chk("R8 toggle/set/clear", {29'd0, match_out}, 32'd3);
        rd(A_EXT, d); chk("R8 readback", d, 32'h1B3);
        idle(4);
        chk("R8 second toggle", {29'd0, match_out}, 32'd2);
        wr(A_EXT, 32'h005);
        idle(5);
        chk("R8 keep code no effect", {29'd0, match_out}, 32'd5);
        rd(A_EXT, d); chk("R8 keep readback", d, 32'h005);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule